// File: doc/BRIEF.md
# Soft Mute Ramp with Zero Detect

This block sits in a digital audio playback path between the serial receiver and the interpolation stage. A sample pair arrives with a one-cycle frame strobe. The block scales both samples by a shared gain and registers the scaled pair. The gain slides toward silence while a mute request is held and slides back toward unity when the request is released. The slide takes a fixed number of frames, and that number depends on the selected speed mode. If the request changes part way through a slide, the slide turns around from the gain it has reached.

The same frame timing drives a watcher on the input samples. It raises a flag once both channels have carried exact zeros for a long unbroken run of frames. It clears the flag on the first frame in which either channel is not zero. Downstream logic can use the flag to quiet the analog stages.

Top module: `softmute_zdet`

## Requirements
- R1: With `speed_mode` = 2'b00 (normal), holding `mute_req` high from unity gain makes the gain fall by 4 of 4096 per frame. The first frame whose output is exactly zero for a full-scale input is the 1025th strobe after the request.
- R2: With `speed_mode` = 2'b01 (double), the fall takes 2048 frames, so the first zero output is at strobe 2049. With 2'b10 or 2'b11 (quad), it takes 4096 frames, so the first zero output is at strobe 4097.
- R3: With `mute_req` low, the gain rises from silence back to unity over the same number of frames as the fall in that mode. The output first equals the input unchanged at strobe 1025, 2049 or 4097.
- R4: If `mute_req` falls before silence is reached, the very next strobe raises the gain from its present value by the mode's step. The climb back to unity takes as many frames as the fall had used.
- R5: Each output is round(input × gain / 4096), rounding half upward, saturated to signed 24 bits. Gain 0 gives exactly 0 and gain 4096 passes the input unchanged. The output of a frame uses the gain held before that strobe and appears one clock after the strobe, marked by a one-cycle `out_vld`.
- R6: `zero_flag` goes high one clock after the 8192nd consecutive strobe on which both inputs are zero. It stays low after the 8191st.
- R7: `zero_flag` goes low one clock after any strobe on which either input is nonzero. This is the same clock in which that frame's output appears.
- R8: A synchronous reset clears both outputs, `out_vld`, `zero_flag` and the zero-run count, and sets the gain to unity. The flag stays low while reset is held.
- R9: Between strobes, changes on the sample inputs have no effect: outputs, gain and flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a valid sample pair |
| mute_req | input | 1 | High requests a slide to silence, low a slide to unity |
| speed_mode | input | 2 | 00 normal, 01 double, 1x quad ramp length |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_out | output | 24 | Scaled left sample, registered |
| right_out | output | 24 | Scaled right sample, registered |
| out_vld | output | 1 | High for one clock when outputs update |
| zero_flag | output | 1 | High after a long run of all-zero input frames |

## Verification
A gain register off by one step shows at the ports within a single frame as a scaled value that differs from the computed product. A wrong step size moves the first exact-zero or first pass-through frame away from strobe 1025, 2049 or 4097. A zero-run counter that miscounts raises the flag one frame early or late, and this shows only at the 8191/8192 boundary. That is why the run is driven to exactly that length. A missed clear shows one clock after the first nonzero frame.

// File: rtl/smz_pkg.sv
package smz_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD_B = 2'b11
  } speed_e;

  // Right shift applied to the normal-mode step for each speed mode
  function automatic logic [1:0] ramp_shift(input logic [1:0] mode);
    case (mode)
      SPD_NORMAL: ramp_shift = 2'd0;
      SPD_DOUBLE: ramp_shift = 2'd1;
      default:    ramp_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int GW        = 13,
  parameter int UNITY_LOG = 12,
  parameter int BASE_LOG  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          mute,
  input  logic [1:0]    mode,
  output logic [GW-1:0] gain
);
  import smz_pkg::*;

  localparam int UNITY    = 1 << UNITY_LOG;
  localparam int STEP_MAX = UNITY >> BASE_LOG;
  localparam logic [GW-1:0] UNITY_G = GW'(UNITY);
  localparam logic [GW-1:0] STEP_G  = GW'(STEP_MAX);

  logic [GW-1:0] step;
  logic [GW:0]   up_sum;
  logic [GW-1:0] g_next;

  always_comb begin
    step   = STEP_G >> ramp_shift(mode);
    up_sum = {1'b0, gain} + {1'b0, step};
    if (mute)
      g_next = (gain > step) ? (gain - step) : '0;
    else
      g_next = (up_sum >= {1'b0, UNITY_G}) ? UNITY_G : up_sum[GW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         gain <= UNITY_G;
    else if (strobe) gain <= g_next;
  end

  AST_GAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    gain <= UNITY_G); // R5
  AST_GAIN_FALLS: assert property (@(posedge clk) disable iff (rst)
    strobe && mute && gain != '0 |=> gain < $past(gain)); // R1
  AST_GAIN_RISES: assert property (@(posedge clk) disable iff (rst)
    strobe && !mute && gain != UNITY_G |=> gain > $past(gain)); // R4
  AST_GAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe |=> ({1'b0, gain} <= {1'b0, $past(gain)} + {1'b0, STEP_G}) &&
               ({1'b0, gain} + {1'b0, STEP_G} >= {1'b0, $past(gain)})); // R2
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(gain)); // R9
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
  parameter int DW        = 24,
  parameter int GW        = 13,
  parameter int UNITY_LOG = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic [GW-1:0]        gain,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  localparam int PW = DW + GW + 1;
  localparam int QW = PW - UNITY_LOG;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (UNITY_LOG - 1);
  localparam logic signed [QW-1:0] MAXV = QW'((1 << (DW - 1)) - 1);
  localparam logic signed [QW-1:0] MINV = -QW'(1 << (DW - 1));
  localparam logic [GW-1:0] UNITY_G = GW'(1 << UNITY_LOG);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [QW-1:0] q;
  logic signed [DW-1:0] sat;

  always_comb begin
    prod = PW'(din) * $signed({1'b0, gain});
    rnd  = (prod + HALF) >>> UNITY_LOG;
    q    = rnd[QW-1:0];
    if (q > MAXV)      sat = MAXV[DW-1:0];
    else if (q < MINV) sat = MINV[DW-1:0];
    else               sat = q[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (strobe) dout <= sat;
  end

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
    strobe && gain == '0 |=> dout == '0); // R5
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
    strobe && gain == UNITY_G |=> dout == $past(din)); // R5
endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
  parameter int DW  = 24,
  parameter int WIN = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          flag
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C  = CW'(WIN);
  localparam logic [CW-1:0] LAST_C = CW'(WIN - 1);

  logic [CW-1:0] run;
  logic          quiet;

  assign quiet = (a == '0) && (b == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      flag <= 1'b0;
    end else if (strobe) begin
      if (quiet) begin
        if (run != WIN_C) run <= run + 1'b1;
        flag <= (run >= LAST_C);
      end else begin
        run  <= '0;
        flag <= 1'b0;
      end
    end
  end

  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
    strobe && !quiet |=> !flag); // R7
  AST_FLAG_RESET: assert property (@(posedge clk)
    rst |=> !flag); // R8
  AST_FLAG_RUN: assert property (@(posedge clk) disable iff (rst)
    flag |-> run == WIN_C); // R6
endmodule

// File: rtl/softmute_zdet.sv
module softmute_zdet #(
  parameter int DW        = 24,
  parameter int GW        = 13,
  parameter int UNITY_LOG = 12,
  parameter int BASE_LOG  = 10,
  parameter int ZWIN      = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_vld,
  input  logic          mute_req,
  input  logic [1:0]    speed_mode,
  input  logic [DW-1:0] left_in,
  input  logic [DW-1:0] right_in,
  output logic [DW-1:0] left_out,
  output logic [DW-1:0] right_out,
  output logic          out_vld,
  output logic          zero_flag
);
  localparam int NCH = 2;

  logic [GW-1:0]        gain;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  gain_ramp #(.GW(GW), .UNITY_LOG(UNITY_LOG), .BASE_LOG(BASE_LOG)) u_ramp (
    .clk(clk), .rst(rst), .strobe(frame_vld), .mute(mute_req),
    .mode(speed_mode), .gain(gain)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sample_scaler #(.DW(DW), .GW(GW), .UNITY_LOG(UNITY_LOG)) u_scale (
      .clk(clk), .rst(rst), .strobe(frame_vld), .gain(gain),
      .din(ch_in[c]), .dout(ch_out[c])
    );
  end

  zero_watch #(.DW(DW), .WIN(ZWIN)) u_zero (
    .clk(clk), .rst(rst), .strobe(frame_vld), .a(left_in), .b(right_in),
    .flag(zero_flag)
  );

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= frame_vld;
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(frame_vld)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> $stable(left_out) && $stable(right_out)); // R9
endmodule

// File: tb/softmute_zdet_test.sv
module softmute_zdet_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_vld = 1'b0;
  logic        mute_req = 1'b0;
  logic [1:0]  speed_mode = 2'b00;
  logic [23:0] left_in = '0, right_in = '0;
  logic [23:0] left_out, right_out;
  logic        out_vld, zero_flag;

  int checks = 0, failures = 0;
  bit done = 0;
  int mg = 4096;      // model gain
  int zc = 0;         // model zero run
  bit zf = 0;         // model flag
  localparam logic [23:0] BIG = 24'h400000;

  always #4 clk = ~clk;

  softmute_zdet uut (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .mute_req(mute_req),
    .speed_mode(speed_mode), .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .out_vld(out_vld),
    .zero_flag(zero_flag)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] scale(input logic [23:0] x, input int g);
    longint p;
    p = longint'($signed(x)) * g;
    p = (p + 2048) >>> 12;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p[23:0];
  endfunction

  function automatic int step_of(input logic [1:0] m);
    return (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
  endfunction

  task automatic do_frame(input logic [23:0] l, input logic [23:0] r, input string tag);
    logic [23:0] el, er, hl, hr;
    bit hf;
    int s;
    left_in = l; right_in = r; frame_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_vld = 1'b0;
    el = scale(l, mg); er = scale(r, mg);
    s = step_of(speed_mode);
    if (mute_req) mg = (mg > s) ? mg - s : 0;
    else          mg = (mg + s >= 4096) ? 4096 : mg + s;
    if (l == 0 && r == 0) begin
      if (zc < 8192) zc++;
      zf = (zc >= 8192);
    end else begin
      zc = 0; zf = 0;
    end
    chk(left_out == el, {tag, " left"}, left_out, el);
    chk(right_out == er, {tag, " right"}, right_out, er);
    chk(zero_flag == zf, {tag, " flag R6/R7"}, zero_flag, zf);
    chk(out_vld == 1'b1, "R5 out_vld", out_vld, 1);
    hl = left_out; hr = right_out; hf = zero_flag;
    left_in = $urandom(); right_in = $urandom();   // ignored between strobes
    @(posedge clk); @(negedge clk);
    chk(left_out == hl && right_out == hr && zero_flag == hf, "R9 idle hold",
        {left_out, right_out}, {hl, hr});
  endtask

  // mute or unmute from an end point; returns first strobe index hitting target
  task automatic ramp(input bit m, input logic [1:0] sp, input int n, input string tag,
                      output int first);
    mute_req = m; speed_mode = sp; first = 0;
    for (int i = 1; i <= n; i++) begin
      do_frame(BIG, $urandom(), tag);
      if (first == 0 && ((m && left_out == 24'h0) || (!m && left_out == BIG))) first = i;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_vld = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    mg = 4096; zc = 0; zf = 0;
    chk(left_out == 0 && right_out == 0, "R8 reset outputs", {left_out, right_out}, 0);
    chk(zero_flag == 0 && out_vld == 0, "R8 reset flag", {zero_flag, out_vld}, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R5: pass-through at unity and corner values
    for (int i = 0; i < 20; i++) do_frame($urandom(), $urandom(), "R5 unity");
    do_frame(24'h7fffff, 24'h800000, "R5 extremes");

    // R1 / R3 normal speed
    ramp(1'b1, 2'b00, 1030, "R1 fall", first);
    chk(first == 1025, "R1 first zero strobe", first, 1025);
    do_frame(24'h7fffff, 24'h800000, "R5 zero gain");
    ramp(1'b0, 2'b00, 1030, "R3 rise", first);
    chk(first == 1025, "R3 first unity strobe", first, 1025);

    // R2 double and quad, R3 rise lengths
    ramp(1'b1, 2'b01, 2052, "R2 fall double", first);
    chk(first == 2049, "R2 double first zero", first, 2049);
    ramp(1'b0, 2'b01, 2052, "R3 rise double", first);
    chk(first == 2049, "R3 double first unity", first, 2049);
    ramp(1'b1, 2'b10, 4100, "R2 fall quad", first);
    chk(first == 4097, "R2 quad first zero", first, 4097);
    ramp(1'b0, 2'b11, 4100, "R3 rise quad", first);
    chk(first == 4097, "R3 quad first unity", first, 4097);

    // R4 reversal mid-ramp: fall 300 frames, then climb must take 300 frames
    ramp(1'b1, 2'b00, 300, "R4 partial fall", first);
    chk(mg == 2896, "R4 model gain", mg, 2896);
    ramp(1'b0, 2'b00, 310, "R4 climb", first);
    chk(first == 301, "R4 climb length", first, 301);
    ramp(1'b1, 2'b10, 777, "R4 quad partial", first);
    ramp(1'b0, 2'b10, 790, "R4 quad climb", first);
    chk(first == 778, "R4 quad climb length", first, 778);

    // R6 / R7 zero detect boundary
    mute_req = 1'b0; speed_mode = 2'b00;
    for (int i = 1; i <= 8191; i++) do_frame(24'h0, 24'h0, "R6 run");
    chk(zero_flag == 1'b0, "R6 low after 8191", zero_flag, 0);
    do_frame(24'h0, 24'h0, "R6 run end");
    chk(zero_flag == 1'b1, "R6 high after 8192", zero_flag, 1);
    do_frame(24'h0, 24'h000001, "R7 right nonzero");
    chk(zero_flag == 1'b0, "R7 immediate drop", zero_flag, 0);
    for (int i = 1; i <= 8195; i++) do_frame(24'h0, 24'h0, "R6 second run");
    chk(zero_flag == 1'b1, "R6 stays high", zero_flag, 1);

    // R8: reset while flag high and while muted
    mute_req = 1'b1;
    for (int i = 0; i < 10; i++) do_frame($urandom(), $urandom(), "R1 mixed");
    do_reset();
    mute_req = 1'b0;
    do_frame(BIG, BIG, "R8 unity after reset");
    chk(left_out == BIG, "R8 gain unity", left_out, BIG);
    for (int i = 0; i < 30; i++) begin
      mute_req = $urandom_range(0, 1);
      speed_mode = 2'($urandom_range(0, 3));
      do_frame($urandom(), $urandom(), "R4 random toggles");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule